// File: doc/BRIEF.md
# Narrow-Read Byte Lane Aligner

This block sits on the requesting side of a 64-bit AXI4 read data channel. When a read asks for fewer bytes per beat than the bus carries, the responding memory places those bytes on the byte lanes picked out by the low address bits and does not shift them. The requester must pull them out itself. The block watches the read address handshake and records the start address, the transfer size and a lane mode. For each returned beat it then works out which lanes carry valid bytes. It produces an output word and a byte-valid mask.

In the default mode the valid bytes are moved down to the least significant end of the output word. A second mode leaves them in their original lanes, which suits a read-modify-write user that wants to merge the bytes back in place. For later beats of an incrementing burst, the block steps the lane window forward. An unaligned start address gives a shortened first beat. The response code and the last-beat flag travel with each beat unchanged. The data path has no registers, and the handshake passes straight through.

Top module: `narrow_rd_align`

## Requirements
- R1: `out_valid` equals `r_valid` and `r_ready` equals `out_ready` in every cycle, including directly after reset.
- R2: Start address, size and lane mode are recorded only in a cycle where both `ar_valid` and `ar_ready` are 1. Changes on `ar_addr`, `ar_size` or `keep_lanes` at any other time have no effect on the outputs.
- R3: Shift mode (`keep_lanes`=0 when recorded): output byte i (bits 8i+7:8i) holds input lane (off+i) for every valid byte, where off is the beat address modulo 8.
- R4: The number of valid bytes in a beat is 2^size minus (off modulo 2^size), so an unaligned start shortens only the first beat. For example, address 5 with size 2 gives 3 bytes.
- R5: In shift mode `out_mask` has its lowest `count` bits set. In keep mode (`keep_lanes`=1) it has bits off to off+count-1 set.
- R6: Every output byte whose `out_mask` bit is 0 reads zero.
- R7: In keep mode the valid bytes stay in their own lanes, with no shift.
- R8: Beat k>0 of a burst uses address (start address with its low size bits cleared) + k*2^size. off is bits [2:0] of that address.
- R9: The beat index advances only on a beat where `r_valid` and `out_ready` are both 1. It returns to beat 0 after a beat with `r_last`=1 and when a new address is recorded. A held beat keeps its lane window.
- R10: `out_resp` and `out_last` equal `r_resp` and `r_last` on every beat.
- R11: A recorded `ar_size` above 3 is treated as 3, a full 8-byte beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_valid | input | 1 | Read address valid (observed) |
| ar_ready | input | 1 | Read address ready (observed) |
| ar_addr | input | ADDR_W | Read start address |
| ar_size | input | 3 | Log2 of bytes per beat |
| keep_lanes | input | 1 | 1 = keep bytes in original lanes, 0 = shift to LSBs |
| r_valid | input | 1 | Read data valid from target |
| r_ready | output | 1 | Read data ready toward target |
| r_data | input | DATA_W | Read data from target |
| r_resp | input | 2 | Read response code |
| r_last | input | 1 | Last beat of burst |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat accepted |
| out_data | output | DATA_W | Aligned or lane-preserved data |
| out_mask | output | DATA_W/8 | Byte-valid mask |
| out_resp | output | 2 | Response code of this beat |
| out_last | output | 1 | Last-beat flag of this beat |

## Verification
The bench builds the block with its default parameters: a 64-bit bus, 32-bit addresses and an 8-bit length field. Start addresses 0 to 15 cover every lane offset, both before and after an 8-byte boundary. Each address is crossed with every size from 1 to 8 bytes, with both lane modes, and with burst lengths of one to four beats. This reaches every lane window, every shortened first beat and every later aligned beat. Stalled beats, an oversized size code, and address-channel activity that is not a handshake are driven on top of the sweep.

// File: rtl/narrow_rd_align.sv
module narrow_rd_align #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ar_valid,
  input  logic                ar_ready,
  input  logic [ADDR_W-1:0]   ar_addr,
  input  logic [2:0]          ar_size,
  input  logic                keep_lanes,
  input  logic                r_valid,
  output logic                r_ready,
  input  logic [DATA_W-1:0]   r_data,
  input  logic [1:0]          r_resp,
  input  logic                r_last,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic [DATA_W/8-1:0] out_mask,
  output logic [1:0]          out_resp,
  output logic                out_last
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int CNT_W = OFF_W + 1;
  localparam logic [2:0] SZ_MAX = 3'(OFF_W);

  logic [ADDR_W-1:0] base_q;
  logic [2:0]        size_q;
  logic              keep_q;
  logic [LEN_W-1:0]  beat_q;

  wire ar_fire   = ar_valid & ar_ready;
  wire beat_fire = r_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      keep_q <= 1'b0;
      beat_q <= '0;
    end else if (ar_fire) begin
      base_q <= ar_addr;
      size_q <= (ar_size > SZ_MAX) ? SZ_MAX : ar_size;
      keep_q <= keep_lanes;
      beat_q <= '0;
    end else if (beat_fire) begin
      beat_q <= r_last ? '0 : beat_q + LEN_W'(1);
    end
  end

  logic [ADDR_W-1:0] span_m1;
  logic [ADDR_W-1:0] beat_addr;
  logic [OFF_W-1:0]  off;
  logic [OFF_W-1:0]  top;
  logic [CNT_W-1:0]  cnt;

  assign span_m1   = (ADDR_W'(1) << size_q) - ADDR_W'(1);
  assign beat_addr = (beat_q == '0) ? base_q
                   : (base_q & ~span_m1) + (ADDR_W'(beat_q) << size_q);
  assign off = beat_addr[OFF_W-1:0];
  assign top = off | span_m1[OFF_W-1:0];
  assign cnt = CNT_W'(top) - CNT_W'(off) + CNT_W'(1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [CNT_W-1:0] src;
    logic             in_win;
    logic             in_low;
    assign src    = CNT_W'(off) + CNT_W'(i);
    assign in_win = (OFF_W'(i) >= off) && (OFF_W'(i) <= top);
    assign in_low = CNT_W'(i) < cnt;
    assign out_mask[i] = keep_q ? in_win : in_low;
    assign out_data[8*i +: 8] =
      keep_q ? (in_win ? r_data[8*i +: 8] : 8'h00)
             : (in_low ? r_data[8*int'(src[OFF_W-1:0]) +: 8] : 8'h00);
  end

  assign out_valid = r_valid;
  assign r_ready   = out_ready;
  assign out_resp  = r_resp;
  assign out_last  = r_last;

  a_r5_low_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !keep_q) |-> (out_mask[0] && ((out_mask & (out_mask + 1'b1)) == '0)));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_mask) <= (1 << size_q)));

  a_r8_later_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat_q != '0) |-> ((off & span_m1[OFF_W-1:0]) == '0));

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !out_ready && !ar_fire) |=> $stable(beat_q));

  a_r9_last_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && r_last && !ar_fire) |=> (beat_q == '0));
endmodule

// File: tb/narrow_rd_align_tb.sv
module narrow_rd_align_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ar_valid = 0, ar_ready = 0, keep_lanes = 0;
  logic [31:0] ar_addr = '0;
  logic [2:0]  ar_size = '0;
  logic        r_valid = 0, r_last = 0, out_ready = 0;
  logic [63:0] r_data = '0;
  logic [1:0]  r_resp = '0;
  logic        r_ready, out_valid, out_last;
  logic [63:0] out_data;
  logic [7:0]  out_mask;
  logic [1:0]  out_resp;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  narrow_rd_align dut_i (
    .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_addr(ar_addr), .ar_size(ar_size), .keep_lanes(keep_lanes),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
    .r_last(r_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_mask(out_mask), .out_resp(out_resp),
    .out_last(out_last));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] byte_mask(input logic [7:0] m);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (m[i]) r[8*i +: 8] = 8'hff;
    return r;
  endfunction

  task automatic model(input longint base, input int sz, input bit keep, input int k,
                       input logic [63:0] d, output logic [63:0] ed, output logic [7:0] em);
    longint nb = 1 << sz;
    longint a  = (k == 0) ? base : ((base / nb) * nb + k * nb);
    int off = int'(a % 8);
    int cnt = int'(nb - (off % nb));
    logic [7:0] lanes = 8'(((1 << cnt) - 1) << off);
    if (keep) begin
      em = lanes;
      ed = d & byte_mask(lanes);
    end else begin
      em = 8'((1 << cnt) - 1);
      ed = (d >> (8*off)) & byte_mask(em);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [2:0] s, input bit keep);
    @(negedge clk);
    ar_addr = a; ar_size = s; keep_lanes = keep;
    ar_valid = 1; ar_ready = 1;
    @(negedge clk);
    ar_ready = 0;
    ar_addr = ~a; ar_size = 3'(s + 1); keep_lanes = ~keep;  // R2 noise, no handshake
  endtask

  task automatic burst(input int base, input int sz_code, input bit keep, input int len,
                       input bit stall);
    int sz = (sz_code > 3) ? 3 : sz_code;
    logic [63:0] ed; logic [7:0] em;
    issue(32'(base), 3'(sz_code), keep);
    for (int k = 0; k < len; k++) begin
      r_data  = 64'h8877665544332211 ^ {8{8'(k*37 + base*5)}};
      r_resp  = 2'(k + base);
      r_last  = (k == len - 1);
      r_valid = 1;
      model(longint'(base), sz, keep, k, r_data, ed, em);
      if (stall && k == 0) begin
        out_ready = 0;
        #1;
        chk("R1 r_ready follows out_ready", 64'(r_ready), 64'(0));
        @(negedge clk);
        chk("R9 held beat keeps window", out_data, ed);
      end
      out_ready = 1;
      #1;
      chk(keep ? "R7/R8 keep data" : "R3/R4/R8 shift data", out_data, ed);
      chk("R5/R6 mask", 64'(out_mask), 64'(em));
      chk("R10 resp/last", {out_resp, out_last}, {r_resp, r_last});
      @(negedge clk);
    end
    r_valid = 0; r_last = 0;
    #1;
    chk("R1 out_valid follows r_valid", 64'(out_valid), 64'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 reset out_valid", 64'(out_valid), 64'(0));
    out_ready = 1; #1;
    chk("R1 reset r_ready", 64'(r_ready), 64'(1));
    // Named corner cases: addr 4 size 2 -> lanes 4..7 at bits 31:0; addr 5 -> 3 bytes (R4)
    burst(4, 2, 0, 1, 0);
    burst(5, 2, 0, 1, 0);
    burst(5, 2, 1, 1, 0);
    burst(3, 6, 0, 2, 0);   // R11 oversized size
    burst(3, 6, 1, 1, 1);   // R11 keep mode with stall
    for (int base = 0; base < 16; base++)
      for (int sz = 0; sz < 4; sz++)
        for (int keep = 0; keep < 2; keep++)
          for (int len = 1; len <= 4; len++)
            burst(base, sz, keep[0], len, (base + len) % 5 == 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule